// File: doc/BRIEF.md
# Transmit Ready Indicator with Staging Buffer and Idle Monitor

This block manages the transmit side of a slave serial port that a host polls, for example over SPI or I2C. A producer offers whole messages to a large staging buffer. Each message is either accepted in full or dropped in full. The block moves accepted bytes, one per cycle, into a small output FIFO, and the host drains that FIFO with read strobes. The serial framing itself is not part of the block. A host-read strobe and a host-activity pulse stand in for it.

A ready pin saves the host from polling. The pin turns active once the staging buffer holds at least a programmed number of bytes. It stays active until the staging buffer is empty. At that point up to the FIFO depth of bytes may still wait for the host. The pin is disabled after reset, and its active level can be programmed.

An idle monitor watches the host. If no host transaction arrives for a programmed number of prescaler ticks, the port is marked idle and new messages are refused. An extended mode replaces this timer with a backlog limit. In that mode the port goes idle only when the bytes offered to it and not yet read reach the limit. Any host transaction clears the idle state.

Top module: `txr_ready_top`

## Requirements
- R1: After reset the ready feature is disabled, `cfg_rdata` reads 0, `txr_pin` is low, `port_idle` is low, `host_avail` is low and `drop_count` is 0.
- R2: Configuration layout: bit 0 is the enable, bit 1 is active-low, bit 2 is extended timeout, and bits [3 +: TH_W] hold the threshold. `txr_pin` equals the internal ready state XOR the active-low bit. While the feature is disabled, the pin rests at its inactive level, which is 1 when active-low is set.
- R3: While enabled, the ready state turns on one cycle after the staging byte count reaches the threshold. It stays off while the count is below the threshold.
- R4: Once on, the ready state stays on while the staging count is non-zero, even if the count falls below the threshold. It turns off one cycle after the staging buffer empties, while the output FIFO may still hold data.
- R5: The output FIFO holds OUT_DEPTH bytes (16 by default). Bytes reach the host in the order they were written. `host_data` shows the oldest byte whenever `host_avail` is 1, and a `host_rd` strobe removes that byte.
- R6: A `msg_req` is accepted only if all of the following hold: its length is between 1 and the free staging space, no earlier message is still being written, and the port is not idle. `msg_ok` pulses one cycle after an accepted request. Any other request is dropped whole, and `drop_count` increments, saturating at its maximum.
- R7: A threshold larger than STAGE_DEPTH never turns the ready state on, even when the staging buffer is full.
- R8: A write that sets enable with a threshold of 0 is invalid. The enable, active-low and threshold fields then become 0, while the extended-timeout bit is still taken from the write.
- R9: With extended mode off, PRESCALE × TIMEOUT_TICKS cycles without `host_act` or `host_rd` set `port_idle`. While idle, every `msg_req` is dropped.
- R10: A `host_act` or `host_rd` restarts the inactivity timer and clears `port_idle` on the next cycle.
- R11: With extended mode on, the timer has no effect. The port goes idle when the backlog reaches BL_LIMIT. The backlog is the sum of all offered message lengths, accepted or dropped, minus the bytes the host has read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | CFG_W | Configuration write value |
| cfg_rdata | output | CFG_W | Configuration readback |
| msg_req | input | 1 | Message offer pulse |
| msg_len | input | CNT_W | Length of the offered message in bytes |
| msg_ok | output | 1 | Offer accepted (one cycle after `msg_req`) |
| wr_valid | input | 1 | Message byte valid |
| wr_data | input | 8 | Message byte |
| host_rd | input | 1 | Host read strobe |
| host_act | input | 1 | Host transaction pulse |
| host_data | output | 8 | Oldest byte in the output FIFO |
| host_avail | output | 1 | Output FIFO not empty |
| txr_pin | output | 1 | Ready pin at its programmed polarity |
| port_idle | output | 1 | Port idle, new messages refused |
| drop_count | output | 16 | Saturating count of dropped messages |

## Verification
The assertions rely on three things about the inputs. The producer sends at most as many `wr_valid` bytes as the length of its last accepted message. It issues `msg_req` only after those bytes are done. Reset is held low from time zero. The stimulus keeps to this by starting a message's bytes only after it has seen `msg_ok`, and by offering a new message only when no bytes remain to be written. Host reads are random and may hit an empty FIFO, which the block must tolerate.

// File: rtl/txr_pkg.sv
// Package: field positions of the configuration word and a helper shared
// by the transmit-ready blocks. Assumes the threshold field is the top field.
package txr_pkg;

    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_POL_BIT = 1;
    localparam int CFG_EXT_BIT = 2;
    localparam int CFG_THR_LSB = 3;

    // Width of the whole configuration word for a given threshold width.
    function automatic int cfg_width(input int thr_w);
        return CFG_THR_LSB + thr_w;
    endfunction

endpackage

// File: rtl/txr_cfg_regs.sv
// Configuration register for the ready feature.
// The enable, active-low and threshold fields are taken only when the write
// is valid. A write that enables with a zero threshold clears those fields.
// The extended-timeout bit is always taken from the write.
module txr_cfg_regs #(
    parameter int TH_W = 12
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_wr,
    input  logic [txr_pkg::cfg_width(TH_W)-1:0] cfg_wdata,
    output logic [txr_pkg::cfg_width(TH_W)-1:0] cfg_rdata,
    output logic                                rdy_en,
    output logic                                rdy_act_low,
    output logic                                ext_to,
    output logic [TH_W-1:0]                     rdy_thr
);
    import txr_pkg::*;

    logic [TH_W-1:0] w_thr;
    logic            w_en;
    logic            w_valid;

    // Purpose: pick out the written fields and judge whether they are valid.
    always_comb begin
        w_thr   = cfg_wdata[CFG_THR_LSB +: TH_W];
        w_en    = cfg_wdata[CFG_EN_BIT];
        w_valid = !(w_en && (w_thr == '0));
    end

    // Purpose: store the fields, or clear the ready fields on an invalid write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_en      <= 1'b0;
            rdy_act_low <= 1'b0;
            ext_to      <= 1'b0;
            rdy_thr     <= '0;
        end else if (cfg_wr) begin
            ext_to <= cfg_wdata[CFG_EXT_BIT];
            if (w_valid) begin
                rdy_en      <= w_en;
                rdy_act_low <= cfg_wdata[CFG_POL_BIT];
                rdy_thr     <= w_thr;
            end else begin
                rdy_en      <= 1'b0;
                rdy_act_low <= 1'b0;
                rdy_thr     <= '0;
            end
        end
    end

    // Purpose: assemble the readback word from the stored fields.
    always_comb begin
        cfg_rdata                      = '0;
        cfg_rdata[CFG_EN_BIT]          = rdy_en;
        cfg_rdata[CFG_POL_BIT]         = rdy_act_low;
        cfg_rdata[CFG_EXT_BIT]         = ext_to;
        cfg_rdata[CFG_THR_LSB +: TH_W] = rdy_thr;
    end

endmodule

// File: rtl/txr_stage_buf.sv
// Staging buffer. Messages are admitted whole: an offer is accepted only when
// its full length fits into the space not yet used or reserved.
// Assumes DEPTH is a power of two so the pointers wrap on their own, and that
// the producer sends no more bytes than the length of the accepted message.
module txr_stage_buf #(
    parameter int DEPTH  = 2048,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_req,
    input  logic [CNT_W-1:0]  msg_len,
    input  logic              block_new,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    input  logic              take,
    output logic              msg_ok,
    output logic [CNT_W-1:0]  stage_cnt,
    output logic [7:0]        head_data,
    output logic [DROP_W-1:0] drop_cnt
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0]       mem [DEPTH];
    logic [AW-1:0]    wp;
    logic [AW-1:0]    rp;
    logic [CNT_W-1:0] remain;
    logic [CNT_W:0]   free_sp;
    logic             accept;
    logic             wr_en;

    // Purpose: work out free space, whether the offer is accepted, and whether a byte is written.
    always_comb begin
        free_sp = (CNT_W + 1)'(DEPTH) - {1'b0, stage_cnt} - {1'b0, remain};
        accept  = msg_req && !block_new && (remain == '0) &&
                  (msg_len != '0) && ({1'b0, msg_len} <= free_sp);
        wr_en   = wr_valid && (remain != '0);
    end

    // Purpose: store the message bytes in the circular array.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wp] <= wr_data;
        end
    end

    // Purpose: keep the pointers, the staging count and the reservation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp        <= '0;
            rp        <= '0;
            remain    <= '0;
            stage_cnt <= '0;
            msg_ok    <= 1'b0;
        end else begin
            msg_ok <= accept;
            if (accept) begin
                remain <= msg_len;
            end else if (wr_en) begin
                remain <= remain - 1'b1;
            end
            if (wr_en) begin
                wp <= wp + 1'b1;
            end
            if (take) begin
                rp <= rp + 1'b1;
            end
            stage_cnt <= stage_cnt + CNT_W'(wr_en) - CNT_W'(take);
        end
    end

    // Purpose: count dropped offers and hold the count at its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_cnt <= '0;
        end else if (msg_req && !accept && (drop_cnt != '1)) begin
            drop_cnt <= drop_cnt + 1'b1;
        end
    end

    // Purpose: show the oldest staged byte to the mover.
    always_comb head_data = mem[rp];

endmodule

// File: rtl/txr_out_fifo.sv
// Small output FIFO that the host drains. Assumes push only when not full;
// a pop while empty is ignored. DEPTH is a power of two.
module txr_out_fifo #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop,
    output logic [7:0]    head,
    output logic          not_empty,
    output logic          full,
    output logic [CW-1:0] count
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic          do_push;
    logic          do_pop;

    // Purpose: qualify the push and pop requests against the fill state.
    always_comb begin
        do_push = push && !full;
        do_pop  = pop && not_empty;
    end

    // Purpose: write the entries.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= push_data;
        end
    end

    // Purpose: update the pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Purpose: derive the flags and the head byte.
    always_comb begin
        not_empty = (count != '0);
        full      = (count == CW'(DEPTH));
        head      = mem[rp];
    end

endmodule

// File: rtl/txr_idle_mon.sv
// Host-inactivity monitor. In normal mode it counts prescaler ticks since the
// last host transaction. In extended mode it tracks the backlog of offered,
// unread bytes against a limit instead. A host transaction clears the idle state.
module txr_idle_mon #(
    parameter int PRESCALE      = 125000,
    parameter int TIMEOUT_TICKS = 2000,
    parameter int BL_LIMIT      = 4096,
    parameter int LEN_W         = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_mode,
    input  logic             host_txn,
    input  logic             msg_req,
    input  logic [LEN_W-1:0] msg_len,
    input  logic             rd_pop,
    output logic             port_idle
);
    localparam int PW = $clog2(PRESCALE + 1);
    localparam int TW = $clog2(TIMEOUT_TICKS + 1);
    localparam int BW = $clog2(BL_LIMIT + 1);
    localparam int SW = ((BW > LEN_W) ? BW : LEN_W) + 1;

    logic [PW-1:0] pre_cnt;
    logic [TW-1:0] tick_cnt;
    logic [BW-1:0] backlog;
    logic [SW-1:0] bl_sum;
    logic          tick;
    logic          timeout_hit;
    logic          backlog_hit;

    // Purpose: detect the prescaler tick, the timeout and the backlog limit.
    always_comb begin
        tick        = (pre_cnt == PW'(PRESCALE - 1));
        timeout_hit = !ext_mode && tick && (tick_cnt == TW'(TIMEOUT_TICKS - 1));
        backlog_hit = ext_mode && (backlog >= BW'(BL_LIMIT));
    end

    // Purpose: run the prescaler and the tick counter; hold them while inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || host_txn || ext_mode || port_idle) begin
            pre_cnt  <= '0;
            tick_cnt <= '0;
        end else if (tick) begin
            pre_cnt  <= '0;
            tick_cnt <= tick_cnt + 1'b1;
        end else begin
            pre_cnt  <= pre_cnt + 1'b1;
        end
    end

    // Purpose: compute the next backlog, floored at zero and clamped at the limit.
    always_comb begin
        bl_sum = SW'(backlog) + (msg_req ? SW'(msg_len) : '0);
        if (rd_pop && (bl_sum != '0)) begin
            bl_sum = bl_sum - 1'b1;
        end
        if (bl_sum > SW'(BL_LIMIT)) begin
            bl_sum = SW'(BL_LIMIT);
        end
    end

    // Purpose: register the backlog.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            backlog <= '0;
        end else begin
            backlog <= bl_sum[BW-1:0];
        end
    end

    // Purpose: set idle on a timeout or on the backlog limit; any host transaction wins.
    always_ff @(posedge clk) begin
        if (!rst_n || host_txn) begin
            port_idle <= 1'b0;
        end else if (timeout_hit || backlog_hit) begin
            port_idle <= 1'b1;
        end
    end

endmodule

// File: rtl/txr_ready_top.sv
// Transmit ready indicator. Connects the configuration register, staging
// buffer, output FIFO and idle monitor. Moves one byte per cycle from staging
// into the output FIFO and drives the ready pin from the staging count, using
// set-at-threshold and clear-at-empty.
// Assumes STAGE_DEPTH and OUT_DEPTH are powers of two.
module txr_ready_top #(
    parameter int STAGE_DEPTH   = 2048,
    parameter int OUT_DEPTH     = 16,
    parameter int PRESCALE      = 125000,
    parameter int TIMEOUT_TICKS = 2000,
    parameter int BL_LIMIT      = 4096
) (
    input  logic                                                  clk,
    input  logic                                                  rst_n,
    input  logic                                                  cfg_wr,
    input  logic [txr_pkg::cfg_width($clog2(STAGE_DEPTH+1))-1:0]  cfg_wdata,
    output logic [txr_pkg::cfg_width($clog2(STAGE_DEPTH+1))-1:0]  cfg_rdata,
    input  logic                                                  msg_req,
    input  logic [$clog2(STAGE_DEPTH+1)-1:0]                      msg_len,
    output logic                                                  msg_ok,
    input  logic                                                  wr_valid,
    input  logic [7:0]                                            wr_data,
    input  logic                                                  host_rd,
    input  logic                                                  host_act,
    output logic [7:0]                                            host_data,
    output logic                                                  host_avail,
    output logic                                                  txr_pin,
    output logic                                                  port_idle,
    output logic [15:0]                                           drop_count
);
    localparam int CNT_W = $clog2(STAGE_DEPTH + 1);
    localparam int TH_W  = CNT_W;
    localparam int OCW   = $clog2(OUT_DEPTH + 1);

    logic             rdy_en;
    logic             rdy_act_low;
    logic             ext_to;
    logic [TH_W-1:0]  rdy_thr;
    logic [CNT_W-1:0] stage_cnt;
    logic [7:0]       stage_head;
    logic             mv_take;
    logic             fifo_full;
    logic [OCW-1:0]   fifo_cnt;
    logic             rd_pop;
    logic             host_txn;
    logic             rdy_on;

    txr_cfg_regs #(.TH_W(TH_W)) i_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .rdy_en      (rdy_en),
        .rdy_act_low (rdy_act_low),
        .ext_to      (ext_to),
        .rdy_thr     (rdy_thr)
    );

    txr_stage_buf #(.DEPTH(STAGE_DEPTH), .CNT_W(CNT_W), .DROP_W(16)) i_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_req   (msg_req),
        .msg_len   (msg_len),
        .block_new (port_idle),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .take      (mv_take),
        .msg_ok    (msg_ok),
        .stage_cnt (stage_cnt),
        .head_data (stage_head),
        .drop_cnt  (drop_count)
    );

    // Purpose: the mover takes a staged byte whenever the FIFO has room; host strobes count as activity.
    always_comb begin
        mv_take  = (stage_cnt != '0) && !fifo_full;
        rd_pop   = host_rd && host_avail;
        host_txn = host_act || host_rd;
    end

    txr_out_fifo #(.DEPTH(OUT_DEPTH), .CW(OCW)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (mv_take),
        .push_data (stage_head),
        .pop       (host_rd),
        .head      (host_data),
        .not_empty (host_avail),
        .full      (fifo_full),
        .count     (fifo_cnt)
    );

    txr_idle_mon #(
        .PRESCALE      (PRESCALE),
        .TIMEOUT_TICKS (TIMEOUT_TICKS),
        .BL_LIMIT      (BL_LIMIT),
        .LEN_W         (CNT_W)
    ) i_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_mode  (ext_to),
        .host_txn  (host_txn),
        .msg_req   (msg_req),
        .msg_len   (msg_len),
        .rd_pop    (rd_pop),
        .port_idle (port_idle)
    );

    // Purpose: ready state sets at the threshold and clears when staging empties.
    always_ff @(posedge clk) begin
        if (!rst_n || !rdy_en) begin
            rdy_on <= 1'b0;
        end else if (stage_cnt >= rdy_thr) begin
            rdy_on <= 1'b1;
        end else if (stage_cnt == '0) begin
            rdy_on <= 1'b0;
        end
    end

    // Purpose: apply the programmed polarity at the pin.
    always_comb txr_pin = rdy_on ^ rdy_act_low;

endmodule

// File: rtl/txr_ready_chk.sv
// Checker for txr_ready_top, attached by bind. Relates the pin, the counts,
// the accept pulse and the idle flag over time.
module txr_ready_chk #(
    parameter int STAGE_DEPTH = 2048,
    parameter int OUT_DEPTH   = 16,
    parameter int CNT_W       = $clog2(STAGE_DEPTH + 1),
    parameter int OCW         = $clog2(OUT_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic             cfg_pol,
    input logic             txr_pin,
    input logic             rdy_on,
    input logic [CNT_W-1:0] stage_cnt,
    input logic [OCW-1:0]   fifo_cnt,
    input logic             msg_req,
    input logic             msg_ok,
    input logic             port_idle,
    input logic             host_act,
    input logic [15:0]      drop_count
);

    p_inactive_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !$past(cfg_en)) |-> (txr_pin == cfg_pol));

    p_ready_needs_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_on |-> ($past(stage_cnt) != '0));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= OCW'(OUT_DEPTH));

    p_stage_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stage_cnt <= CNT_W'(STAGE_DEPTH));

    p_drop_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req && port_idle && (drop_count != 16'hFFFF)) |=>
        (drop_count == $past(drop_count) + 16'd1));

    p_idle_refuses_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req && port_idle) |=> !msg_ok);

    p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_act |=> !port_idle);

endmodule

bind txr_ready_top txr_ready_chk #(
    .STAGE_DEPTH (STAGE_DEPTH),
    .OUT_DEPTH   (OUT_DEPTH)
) i_txr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_rdata[0]),
    .cfg_pol    (cfg_rdata[1]),
    .txr_pin    (txr_pin),
    .rdy_on     (rdy_on),
    .stage_cnt  (stage_cnt),
    .fifo_cnt   (fifo_cnt),
    .msg_req    (msg_req),
    .msg_ok     (msg_ok),
    .port_idle  (port_idle),
    .host_act   (host_act),
    .drop_count (drop_count)
);

// File: tb/test_txr_ready_top.sv
`timescale 1ns/1ps
module test_txr_ready_top;
    localparam int SD    = 64;
    localparam int OD    = 16;
    localparam int PS    = 4;
    localparam int TT    = 8;
    localparam int BL    = 128;
    localparam int CNT_W = $clog2(SD + 1);
    localparam int CFG_W = 3 + CNT_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic [CFG_W-1:0] cfg_rdata;
    logic             msg_req = 1'b0;
    logic [CNT_W-1:0] msg_len = '0;
    logic             msg_ok;
    logic             wr_valid = 1'b0;
    logic [7:0]       wr_data = '0;
    logic             host_rd = 1'b0;
    logic             host_act = 1'b0;
    logic [7:0]       host_data;
    logic             host_avail;
    logic             txr_pin;
    logic             port_idle;
    logic [15:0]      drop_count;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  tot      = 0;   // bytes written and not yet read
    int  bl       = 0;   // backlog model
    int  drops    = 0;
    logic [7:0] sb[$];

    always #4 clk = ~clk;

    txr_ready_top #(
        .STAGE_DEPTH(SD), .OUT_DEPTH(OD), .PRESCALE(PS),
        .TIMEOUT_TICKS(TT), .BL_LIMIT(BL)
    ) i_txr_ready_top (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .msg_req(msg_req), .msg_len(msg_len),
        .msg_ok(msg_ok), .wr_valid(wr_valid), .wr_data(wr_data),
        .host_rd(host_rd), .host_act(host_act), .host_data(host_data),
        .host_avail(host_avail), .txr_pin(txr_pin), .port_idle(port_idle),
        .drop_count(drop_count)
    );

    task automatic chk_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Configuration word: en bit0, active-low bit1, extended bit2, threshold from bit3.
    function automatic logic [CFG_W-1:0] cfgw(input int en, input int pol, input int ext, input int thr);
        return CFG_W'(en | (pol << 1) | (ext << 2) | (thr << 3));
    endfunction

    function automatic int bl_add(input int b, input int n);
        return (b + n > BL) ? BL : b + n;
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [CFG_W-1:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Offer a message; exp = 1 accept, 0 drop, -1 either. Streams bytes when accepted.
    task automatic send_msg(input int len, input int exp, input string req, output bit ok);
        msg_req = 1'b1; msg_len = CNT_W'(len);
        bl = bl_add(bl, len);
        @(negedge clk);
        msg_req = 1'b0;
        ok = msg_ok;
        if (exp >= 0) chk_eq(req, int'(ok), exp);
        if (!ok) drops++;
        if (ok) begin
            for (int i = 0; i < len; i++) begin
                wr_valid = 1'b1; wr_data = 8'($urandom);
                sb.push_back(wr_data); tot++;
                @(negedge clk);
            end
            wr_valid = 1'b0;
        end
    endtask

    task automatic rd_one();
        if (host_avail) begin
            if (sb.size() == 0) chk_eq("R5 unexpected byte", int'(host_data), -1);
            else chk_eq("R5 byte order", int'(host_data), int'(sb.pop_front()));
            tot--;
            if (bl > 0) bl--;
        end
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic drain(output int n);
        n = 0;
        while (host_avail && n < 500) begin
            rd_one();
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk_eq("WATCHDOG expired", 0, 1);
        report();
        $finish;
    end

    initial begin : main
        bit ok;
        int n;
        int need;
        process::self().srandom(32'd20240611);
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 cfg_rdata", int'(cfg_rdata), 0);
        chk_eq("R1 txr_pin", int'(txr_pin), 0);
        chk_eq("R1 port_idle", int'(port_idle), 0);
        chk_eq("R1 host_avail", int'(host_avail), 0);
        chk_eq("R1 drop_count", int'(drop_count), 0);

        // R2 disabled with active-low: pin rests high
        cfg_write(cfgw(0, 1, 0, 0));
        chk_eq("R2 readback", int'(cfg_rdata), 2);
        chk_eq("R2 inactive level", int'(txr_pin), 1);

        // R8 invalid: enable with zero threshold, extended bit kept
        cfg_write(cfgw(1, 1, 1, 0));
        chk_eq("R8 readback", int'(cfg_rdata), 4);
        chk_eq("R8 pin low", int'(txr_pin), 0);

        // R3/R4/R5 active-low, threshold 10, extended mode so the timer stays out
        cfg_write(cfgw(1, 1, 1, 10));
        chk_eq("R2 idle level active-low", int'(txr_pin), 1);
        send_msg(20, 1, "R6 accept 20", ok);
        send_msg(5, 1, "R6 accept 5", ok);
        wait_n(3);
        chk_eq("R3 below threshold (9)", int'(txr_pin), 1);
        send_msg(1, 1, "R6 accept 1", ok);
        wait_n(3);
        chk_eq("R3 at threshold (10)", int'(txr_pin), 0);
        chk_eq("R5 host_avail", int'(host_avail), 1);
        repeat (4) rd_one();
        wait_n(3);
        chk_eq("R4 held below threshold", int'(txr_pin), 0);
        repeat (6) rd_one();
        wait_n(3);
        chk_eq("R4 cleared at empty staging", int'(txr_pin), 1);
        chk_eq("R4 fifo still holds data", int'(host_avail), 1);
        drain(n);
        chk_eq("R5 fifo depth", n, OD);

        // R7 / R6: threshold above capacity, active-high
        cfg_write(cfgw(1, 0, 1, SD + 1));
        send_msg(40, 1, "R6 accept 40", ok);
        wait_n(2);
        send_msg(40, 1, "R6 accept exact free", ok);
        wait_n(3);
        send_msg(1, 0, "R6 drop when full", ok);
        send_msg(0, 0, "R6 drop zero length", ok);
        chk_eq("R6 drop_count", int'(drop_count), drops);
        chk_eq("R7 never asserts", int'(txr_pin), 0);
        drain(n);
        chk_eq("R7 all bytes delivered", n, 80);

        // R9 / R10 timeout
        cfg_write(cfgw(0, 0, 0, 0));
        host_act = 1'b1; @(negedge clk); host_act = 1'b0;
        wait_n(20);
        chk_eq("R9 not yet idle", int'(port_idle), 0);
        wait_n(20);
        chk_eq("R9 idle after timeout", int'(port_idle), 1);
        send_msg(4, 0, "R9 drop while idle", ok);
        chk_eq("R9 drop_count", int'(drop_count), drops);
        host_act = 1'b1; @(negedge clk); host_act = 1'b0;
        chk_eq("R10 wake", int'(port_idle), 0);
        wait_n(20);
        chk_eq("R10 timer restarted", int'(port_idle), 0);
        send_msg(4, 1, "R10 accept after wake", ok);
        wait_n(2);
        drain(n);

        // R11 extended mode
        cfg_write(cfgw(0, 0, 1, 0));
        wait_n(60);
        chk_eq("R11 timer ignored", int'(port_idle), 0);
        send_msg(60, 1, "R11 accept 60", ok);
        wait_n(3);
        send_msg(60, 0, "R11 drop 60", ok);
        need = BL - bl;
        send_msg(need, 1, "R11 final offer", ok);
        wait_n(2);
        chk_eq("R11 idle at backlog limit", int'(port_idle), 1);
        repeat (3) rd_one();
        wait_n(2);
        chk_eq("R11 idle cleared below limit", int'(port_idle), 0);
        drain(n);
        chk_eq("R11 drained all", tot, 0);

        // Random phase: normal mode, frequent host reads
        cfg_write(cfgw(1, 0, 0, 20));
        begin
            int rem = 0;
            bit pend = 0;
            int plen = 0;
            int must = -1;
            for (int cyc = 0; cyc < 4000; cyc++) begin
                if (pend) begin
                    if (must >= 0) chk_eq("R6 random accept", int'(msg_ok), must);
                    if (msg_ok) rem = plen; else drops++;
                    pend = 0;
                end
                msg_req = 1'b0; wr_valid = 1'b0; host_rd = 1'b0;
                if (rem > 0) begin
                    wr_valid = 1'b1; wr_data = 8'($urandom);
                    sb.push_back(wr_data); tot++; rem--;
                end else if (($urandom % 4) == 0) begin
                    plen = 1 + int'($urandom % 40);
                    msg_req = 1'b1; msg_len = CNT_W'(plen);
                    if (plen <= SD - tot) must = 1;
                    else if (plen > SD + OD - tot) must = 0;
                    else must = -1;
                    pend = 1;
                end
                if (($urandom % 2) == 0) begin
                    if (host_avail) begin
                        if (sb.size() == 0) chk_eq("R5 unexpected byte", int'(host_data), -1);
                        else chk_eq("R5 random order", int'(host_data), int'(sb.pop_front()));
                        tot--;
                    end
                    host_rd = 1'b1;
                end
                @(negedge clk);
            end
            msg_req = 1'b0; wr_valid = 1'b0; host_rd = 1'b0;
            if (pend) begin
                if (msg_ok) begin
                    for (int i = 0; i < plen; i++) begin
                        wr_valid = 1'b1; wr_data = 8'($urandom);
                        sb.push_back(wr_data); tot++;
                        @(negedge clk);
                    end
                    wr_valid = 1'b0;
                end else drops++;
            end else if (rem > 0) begin
                for (int i = 0; i < rem; i++) begin
                    wr_valid = 1'b1; wr_data = 8'($urandom);
                    sb.push_back(wr_data); tot++;
                    @(negedge clk);
                end
                wr_valid = 1'b0;
            end
        end
        wait_n(3);
        drain(n);
        chk_eq("R5 random all delivered", sb.size(), 0);
        chk_eq("R6 random drop_count", int'(drop_count), drops);
        report();
        $finish;
    end
endmodule